// File: doc/BRIEF.md
# Four-Channel DMA Transfer Controller

This block is a bus-master DMA engine with four channels. Each channel is set up independently. While the block does not own the bus, a host CPU programs it through a small byte-wide register port. For every channel the host sets a 16-bit start address, a 14-bit transfer count, a transfer kind, and an enable bit.

Once an enabled channel's peripheral raises its request, the block asks the CPU for the bus. It waits for the hold acknowledge before doing anything else. It then runs one transfer at a time, and each transfer has two phases. The first is a single address phase, where a strobe latches the upper address byte from a separate output. The second is a transfer phase, which drives the memory and I/O strobes and the channel's active-low acknowledge.

After every transfer the address goes up by one and the count goes down by one. Channels are re-arbitrated by fixed priority. A terminal-count output flags the last transfer of a channel, and a mark output flags every 128th transfer since reset.

Top module: `dma_quad`

## Requirements
- R1: At most one bit of `dack_n` is low at any time. Bit i goes low only during the transfer phase of a transfer that serves channel i.
- R2: When several enabled channels request at once, the lowest-numbered one is served first. Arbitration is repeated after every transfer, so channel 0 has the highest priority and channel 3 the lowest.
- R3: An enabled request raises `hold_req`. No address phase starts until `hold_ack` has been sampled high while `hold_req` is high.
- R4: Bits 7:6 of the count-high byte set the transfer kind, and the strobes are active only in the transfer phase. Kind 2'b10 (read) drives `mem_rd_n` and `io_wr_n` low. Kind 2'b01 (write) drives `mem_wr_n` and `io_rd_n` low. Kinds 2'b00 and 2'b11 (verify) drive no strobe.
- R5: A programmed count N gives N+1 transfers. The address rises by one per transfer and wraps at 16 bits. `tc` is high only on the final transfer, after which that channel's enable bit reads back as 0.
- R6: `mark` is high on every transfer whose ordinal since reset is a multiple of 128. This holds even when that transfer is also the terminal one.
- R7: Each transfer opens with exactly one address-phase cycle. In that cycle `addr_stb` is high, `addr_hi`/`addr_lo` carry the 16-bit address and every `dack_n` bit is high. The transfer phase follows directly.
- R8: While `ready` is low the transfer phase is stretched by one cycle per low cycle, with address and acknowledge held steady.
- R9: Reset clears all enable bits and leaves `hold_req`, `bus_en` and all strobes inactive. After reset a request alone causes no bus request.
- R10: The register port is decoded from `reg_sel` as follows. 4'b0cc0 is channel cc's address and 4'b0cc1 is its count; the count high byte is {kind, count[13:8]}. 4'b1000 is the enable mask in bits 3:0. A shared byte pointer selects the lower byte first and toggles on each access to a channel register. A write to 4'b1000 clears the pointer. Accesses are ignored while `reg_cs_n` is high or `bus_en` is high.
- R11: After a transfer, `hold_req` stays high if any enabled request is still pending. Otherwise it drops, and the next request starts a new bus request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_cs_n | input | 1 | Register port select, active low |
| reg_wr | input | 1 | Register write enable |
| reg_rd | input | 1 | Register read enable (advances byte pointer) |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte |
| dreq | input | 4 | Per-channel transfer requests |
| dack_n | output | 4 | Per-channel acknowledges, active low |
| hold_req | output | 1 | Bus request to the CPU |
| hold_ack | input | 1 | Bus granted by the CPU |
| ready | input | 1 | Transfer may complete; low inserts wait cycles |
| bus_en | output | 1 | Block owns the address and control lines |
| addr_stb | output | 1 | Upper address byte strobe |
| addr_lo | output | 8 | Lower address byte |
| addr_hi | output | 8 | Upper address byte for the external latch |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | Peripheral read strobe, active low |
| io_wr_n | output | 1 | Peripheral write strobe, active low |
| tc | output | 1 | Final transfer of the channel |
| mark | output | 1 | Every 128th transfer since reset |

## Verification
Terminal count and the progress mark come from separate counters: the per-channel count and a global ordinal since reset. Both can fire on the same transfer. The bench provokes this right after a reset by programming one channel with count 127, so its 128th and last transfer is also the 128th since reset. The bench then requires exactly one transfer carrying both `tc` and `mark`, no other mark, and one terminal count. Throughout the run a monitor also compares `mark` on every completed transfer with the ordinal it has counted itself.

// File: rtl/dma_quad.sv
module dma_quad #(
  parameter int MARK_EVERY = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_cs_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [3:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [3:0] dreq,
  output logic [3:0] dack_n,
  output logic       hold_req,
  input  logic       hold_ack,
  input  logic       ready,
  output logic       bus_en,
  output logic       addr_stb,
  output logic [7:0] addr_lo,
  output logic [7:0] addr_hi,
  output logic       mem_rd_n,
  output logic       mem_wr_n,
  output logic       io_rd_n,
  output logic       io_wr_n,
  output logic       tc,
  output logic       mark
);
  localparam int NCH = 4;
  localparam int AW  = 16;
  localparam int CW  = 14;
  localparam int MW  = $clog2(MARK_EVERY);
  localparam logic [1:0] K_WRITE  = 2'b01;
  localparam logic [1:0] K_READ   = 2'b10;
  localparam logic [3:0] SEL_MODE = 4'b1000;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_ADDR, S_XFER} state_t;

  state_t         st;
  logic [1:0]     ch;
  logic [NCH-1:0] en;
  logic [AW-1:0]  addr_q [NCH];
  logic [CW-1:0]  cnt_q  [NCH];
  logic [1:0]     kind_q [NCH];
  logic           ff;
  logic [MW-1:0]  xcnt;

  logic [NCH-1:0] pend, pend_nx, en_nx;
  logic [1:0]     pick, rch;
  logic           xf, done, last, acc, wr_ok, rd_ok, chreg;

  assign pend = dreq & en;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend[i]) pick = 2'(i);
  end

  assign xf      = (st == S_XFER);
  assign done    = xf && ready;
  assign last    = (cnt_q[ch] == '0);
  assign en_nx   = en & ~((done && last) ? (NCH'(1) << ch) : '0);
  assign pend_nx = dreq & en_nx;

  assign acc   = !reg_cs_n && !bus_en;
  assign wr_ok = acc && reg_wr;
  assign rd_ok = acc && reg_rd;
  assign chreg = !reg_sel[3];
  assign rch   = reg_sel[2:1];

  always_comb begin
    if (reg_sel == SEL_MODE)
      reg_rdata = {{(8-NCH){1'b0}}, en};
    else if (reg_sel[3])
      reg_rdata = '0;
    else if (!reg_sel[0])
      reg_rdata = ff ? addr_q[rch][AW-1:8] : addr_q[rch][7:0];
    else
      reg_rdata = ff ? {kind_q[rch], cnt_q[rch][CW-1:8]} : cnt_q[rch][7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      ch   <= '0;
      en   <= '0;
      ff   <= 1'b0;
      xcnt <= '0;
      for (int i = 0; i < NCH; i++) begin
        addr_q[i] <= '0;
        cnt_q[i]  <= '0;
        kind_q[i] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (|pend) st <= S_REQ;
        S_REQ: begin
          if (!(|pend)) st <= S_IDLE;
          else if (hold_ack) begin
            ch <= pick;
            st <= S_ADDR;
          end
        end
        S_ADDR: st <= S_XFER;
        default: if (ready) st <= (|pend_nx) ? S_REQ : S_IDLE;
      endcase

      if (done) begin
        addr_q[ch] <= addr_q[ch] + 1'b1;
        cnt_q[ch]  <= cnt_q[ch] - 1'b1;
        xcnt       <= xcnt + 1'b1;
      end

      en <= en_nx;
      if (wr_ok && reg_sel == SEL_MODE) begin
        en <= reg_wdata[NCH-1:0];
        ff <= 1'b0;
      end

      if (wr_ok && chreg) begin
        ff <= !ff;
        if (!reg_sel[0]) begin
          if (ff) addr_q[rch][AW-1:8] <= reg_wdata;
          else    addr_q[rch][7:0]    <= reg_wdata;
        end else begin
          if (ff) begin
            kind_q[rch]         <= reg_wdata[7:6];
            cnt_q[rch][CW-1:8]  <= reg_wdata[CW-9:0];
          end else begin
            cnt_q[rch][7:0] <= reg_wdata;
          end
        end
      end else if (rd_ok && chreg) begin
        ff <= !ff;
      end
    end
  end

  assign hold_req = (st != S_IDLE);
  assign bus_en   = (st == S_ADDR) || xf;
  assign addr_stb = (st == S_ADDR);
  assign addr_lo  = bus_en ? addr_q[ch][7:0]    : '0;
  assign addr_hi  = bus_en ? addr_q[ch][AW-1:8] : '0;
  assign mem_rd_n = !(xf && kind_q[ch] == K_READ);
  assign io_wr_n  = !(xf && kind_q[ch] == K_READ);
  assign mem_wr_n = !(xf && kind_q[ch] == K_WRITE);
  assign io_rd_n  = !(xf && kind_q[ch] == K_WRITE);
  assign dack_n   = xf ? ~(NCH'(1) << ch) : '1;
  assign tc       = xf && last;
  assign mark     = xf && (xcnt == MW'(MARK_EVERY - 1));
endmodule

// File: rtl/dma_quad_chk.sv
module dma_quad_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] dack_n,
  input logic       hold_req,
  input logic       hold_ack,
  input logic       ready,
  input logic       bus_en,
  input logic       addr_stb,
  input logic [7:0] addr_lo,
  input logic [7:0] addr_hi,
  input logic       mem_rd_n,
  input logic       mem_wr_n,
  input logic       io_rd_n,
  input logic       io_wr_n,
  input logic       tc
);
  assert_ack_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dack_n));

  assert_bus_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !$past(bus_en)) |-> $past(hold_ack));

  assert_read_pair_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_rd_n |-> (!io_wr_n && mem_wr_n && io_rd_n));

  assert_write_pair_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_wr_n |-> (!io_rd_n && mem_rd_n && io_wr_n));

  assert_tc_in_xfer_R5: assert property (@(posedge clk) disable iff (rst)
    tc |-> (bus_en && !addr_stb && dack_n != 4'hF));

  assert_stb_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    addr_stb |=> (!addr_stb && bus_en && dack_n != 4'hF));

  assert_wait_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !addr_stb && !ready) |=>
      (bus_en && !addr_stb && $stable(addr_lo) && $stable(addr_hi) && $stable(dack_n)));

  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!hold_req && !bus_en && dack_n == 4'hF));

  assert_bus_needs_hold_R11: assert property (@(posedge clk) disable iff (rst)
    bus_en |-> hold_req);
endmodule

bind dma_quad dma_quad_chk u_chk (
  .clk(clk), .rst(rst), .dack_n(dack_n), .hold_req(hold_req),
  .hold_ack(hold_ack), .ready(ready), .bus_en(bus_en), .addr_stb(addr_stb),
  .addr_lo(addr_lo), .addr_hi(addr_hi), .mem_rd_n(mem_rd_n),
  .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .tc(tc)
);

// File: tb/dma_quad_tb.sv
`timescale 1ns/1ps
module dma_quad_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic reg_cs_n = 1'b1, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [3:0] dreq = '0, dack_n;
  logic hold_req, hold_ack = 1'b0, ready = 1'b1;
  logic bus_en, addr_stb, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, tc, mark;
  logic [7:0] addr_lo, addr_hi;
  logic ack_en = 1'b1;

  always #2 clk = ~clk;

  dma_quad u_dut (
    .clk(clk), .rst(rst), .reg_cs_n(reg_cs_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dreq(dreq), .dack_n(dack_n), .hold_req(hold_req), .hold_ack(hold_ack),
    .ready(ready), .bus_en(bus_en), .addr_stb(addr_stb), .addr_lo(addr_lo),
    .addr_hi(addr_hi), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .tc(tc), .mark(mark)
  );

  always @(posedge clk) hold_ack <= !rst && ack_en && hold_req;

  int errs = 0, checks = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  int ncomp, tc_cnt, tc_last, strb_mix, drops, dack_cyc, last_dack;
  int tot, mark_err, mark_cnt, both;
  int ch_log [64];
  logic [15:0] first_addr, last_addr, cur_addr;
  logic [3:0] strb_first;
  logic prev_hold;

  function automatic int dch(input logic [3:0] d);
    for (int i = 0; i < 4; i++) if (!d[i]) return i;
    return -1;
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      tot = 0; mark_err = 0; prev_hold = 1'b0;
    end else begin
      if (prev_hold && !hold_req) drops++;
      prev_hold = hold_req;
      if (addr_stb) begin
        cur_addr = {addr_hi, addr_lo};
        dack_cyc = 0;
      end
      if (dack_n != 4'hF) dack_cyc++;
      if (bus_en && !addr_stb && ready) begin
        if (ncomp < 64) ch_log[ncomp] = dch(dack_n);
        if (ncomp == 0) begin
          first_addr = cur_addr;
          strb_first = {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n};
        end else if (strb_first != {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}) strb_mix++;
        last_addr = cur_addr;
        tc_cnt += int'(tc);
        tc_last = int'(tc);
        if (mark != ((tot % 128) == 127)) mark_err++;
        if (mark) mark_cnt++;
        if (mark && tc) both++;
        last_dack = dack_cyc;
        ncomp++;
        tot++;
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clr();
    ncomp = 0; tc_cnt = 0; tc_last = 0; strb_mix = 0; drops = 0;
    mark_cnt = 0; both = 0; last_dack = 0;
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    tick(); reg_cs_n = 1'b0; reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    tick(); reg_cs_n = 1'b1; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [7:0] d);
    tick(); reg_cs_n = 1'b0; reg_rd = 1'b1; reg_sel = s;
    @(negedge clk); d = reg_rdata;
    tick(); reg_cs_n = 1'b1; reg_rd = 1'b0;
  endtask

  task automatic prog(input int c, input logic [1:0] k, input logic [15:0] a, input logic [13:0] n);
    wr({1'b0, 2'(c), 1'b0}, a[7:0]);
    wr({1'b0, 2'(c), 1'b0}, a[15:8]);
    wr({1'b0, 2'(c), 1'b1}, n[7:0]);
    wr({1'b0, 2'(c), 1'b1}, {k, n[13:8]});
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (hold_req) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; dreq = '0; ready = 1'b1; ack_en = 1'b1;
    repeat (4) tick();
    rst = 1'b0;
    tick();
  endtask

  function automatic logic [3:0] exp_strb(input logic [1:0] k);
    if (k == 2'b10) return 4'b0110;
    if (k == 2'b01) return 4'b1001;
    return 4'b1111;
  endfunction

  localparam int NV = 5;
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 2'b10, 16'h1234, 14'd3},
    {2'd1, 2'b01, 16'h00FE, 14'd4},
    {2'd2, 2'b00, 16'hFFFF, 14'd1},
    {2'd3, 2'b11, 16'h8000, 14'd0},
    {2'd2, 2'b10, 16'h4321, 14'd2}
  };

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] b;
    clr();
    do_reset();

    @(negedge clk);
    chk("R9", "hold_req after reset", hold_req, 0);
    chk("R9", "bus_en after reset", bus_en, 0);
    chk("R9", "dack_n after reset", dack_n, 4'hF);
    chk("R9", "strobes after reset", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 4'hF);
    rd(4'b1000, b);
    chk("R9", "enable mask after reset", b, 0);
    tick(); dreq = 4'hF;
    repeat (5) @(negedge clk);
    chk("R9", "no hold without enable", hold_req, 0);
    tick(); dreq = '0;

    wr(4'b0100, 8'hA5); wr(4'b0100, 8'h5A);
    rd(4'b0100, b); chk("R10", "addr low byte", b, 8'hA5);
    rd(4'b0100, b); chk("R10", "addr high byte", b, 8'h5A);
    tick(); reg_cs_n = 1'b1; reg_wr = 1'b1; reg_sel = 4'b0100; reg_wdata = 8'hFF;
    tick(); reg_wr = 1'b0;
    rd(4'b0100, b); chk("R10", "cs high write ignored low", b, 8'hA5);
    rd(4'b0100, b); chk("R10", "cs high write ignored high", b, 8'h5A);
    wr(4'b0100, 8'h11); wr(4'b1000, 8'h00); wr(4'b0100, 8'h22); wr(4'b1000, 8'h00);
    rd(4'b0100, b); chk("R10", "pointer cleared, low", b, 8'h22);
    rd(4'b0100, b); chk("R10", "pointer cleared, high", b, 8'h5A);

    for (int v = 0; v < NV; v++) begin
      int c;
      logic [1:0] k;
      logic [15:0] a;
      logic [13:0] n;
      c = int'(VEC[v][33:32]); k = VEC[v][31:30]; a = VEC[v][29:14]; n = VEC[v][13:0];
      prog(c, k, a, n);
      clr();
      wr(4'b1000, 8'(4'(1) << c));
      tick(); dreq = 4'(1) << c;
      wait_idle();
      tick(); dreq = '0;
      chk("R5", "transfer count", ncomp, int'(n) + 1);
      chk("R7", "first latched address", first_addr, a);
      chk("R5", "last address", last_addr, 16'(a + 16'(n)));
      chk("R4", "strobe pattern", strb_first, exp_strb(k));
      chk("R4", "strobe pattern constant", strb_mix, 0);
      chk("R5", "single tc on final", {tc_cnt, tc_last}, {32'd1, 32'd1});
      chk("R1", "acknowledged channel", ch_log[0], c);
      chk("R11", "hold drops once", drops, 1);
      rd(4'b1000, b);
      chk("R5", "enable cleared at tc", b, 0);
    end

    prog(0, 2'b10, 16'h0100, 14'd1);
    prog(1, 2'b10, 16'h0200, 14'd1);
    prog(2, 2'b10, 16'h0300, 14'd1);
    prog(3, 2'b10, 16'h0400, 14'd1);
    clr();
    tick(); dreq = 4'hF;
    wr(4'b1000, 8'h0F);
    wait_idle();
    tick(); dreq = '0;
    chk("R2", "burst length", ncomp, 8);
    for (int i = 0; i < 8; i++) chk("R2", "priority order", ch_log[i], i / 2);
    chk("R11", "hold kept across burst", drops, 1);

    prog(3, 2'b01, 16'h0500, 14'd5);
    prog(1, 2'b01, 16'h0600, 14'd0);
    clr();
    wr(4'b1000, 8'h0A);
    tick(); dreq = 4'h8;
    do begin @(negedge clk); #1; end while (ncomp < 2);
    tick(); dreq = 4'hA;
    wait_idle();
    tick(); dreq = '0;
    chk("R2", "late request count", ncomp, 7);
    chk("R2", "higher priority taken next", ch_log[2], 1);
    chk("R11", "re-arbitrated back", ch_log[3], 3);

    prog(0, 2'b10, 16'h0700, 14'd0);
    clr();
    tick(); ack_en = 1'b0;
    wr(4'b1000, 8'h01);
    tick(); dreq = 4'h1;
    repeat (8) @(negedge clk);
    chk("R3", "hold requested", hold_req, 1);
    chk("R3", "no bus without ack", bus_en, 0);
    chk("R3", "no transfer without ack", ncomp, 0);
    tick(); ack_en = 1'b1;
    wait_idle();
    tick(); dreq = '0;
    chk("R3", "transfer after ack", ncomp, 1);

    prog(2, 2'b01, 16'h0800, 14'd0);
    clr();
    tick(); ready = 1'b0;
    wr(4'b1000, 8'h04);
    tick(); dreq = 4'h4;
    do @(negedge clk); while (dack_n == 4'hF);
    repeat (4) @(posedge clk);
    #1 ready = 1'b1;
    wait_idle();
    tick(); dreq = '0;
    chk("R8", "acknowledge length with 4 waits", last_dack, 5);
    chk("R8", "one transfer", ncomp, 1);

    prog(0, 2'b10, 16'h0900, 14'd1);
    clr();
    tick(); ready = 1'b0;
    wr(4'b1000, 8'h01);
    tick(); dreq = 4'h1;
    do @(negedge clk); while (!(bus_en && !addr_stb));
    wr(4'b1000, 8'h00);
    tick(); ready = 1'b1;
    wait_idle();
    tick(); dreq = '0;
    chk("R10", "write ignored while bus owned", ncomp, 2);

    chk("R6", "mark agrees before reset", mark_err, 0);
    do_reset();
    prog(1, 2'b00, 16'h2000, 14'd127);
    clr();
    wr(4'b1000, 8'h02);
    tick(); dreq = 4'h2;
    wait_idle();
    tick(); dreq = '0;
    chk("R5", "128 transfers", ncomp, 128);
    chk("R6", "mark and tc together", both, 1);
    chk("R6", "single mark", mark_cnt, 1);
    chk("R5", "single tc", tc_cnt, 1);
    chk("R4", "verify has no strobes", strb_first, 4'hF);
    chk("R6", "mark agrees after reset", mark_err, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule